// File: doc/BRIEF.md
# Platform Interrupt Controller Core

This block gathers a parameterised set of external interrupt inputs and routes them to a small number of processor contexts. Each input passes through its own gateway. The gateway turns a high level, or a rising edge, into a latched pending bit. Once an input has been taken, the gateway refuses further requests from it until software reports that the input has been serviced.

Software reaches the block through a fixed, word-addressed register map on a simple single-cycle bus. A read returns data in the cycle it is presented. A write takes effect at the next clock edge. Each context has its own enable vector, priority threshold and claim/complete register. Each context also has an interrupt line, which is high whenever the context has at least one eligible source. A handler reads the claim register to take the best source. It then writes the same ID back to the claim register to re-open that source's gateway.

Top module: `pic_core`

## Requirements
- R1: Source ID 0 is absent. Its priority word (byte address 0), its pending bit and its enable bits always read 0, and writes to them have no effect.
- R2: The register map uses byte addresses, word aligned. Source i has its priority at 4*i. Pending bits start at 0x1000, with source i at bit i%32 of word i/32. The enable vector of context k starts at 0x2000 + 0x80*k, using the same bit packing. The threshold of context k is at 0x200000 + 0x1000*k, and its claim/complete register is 4 bytes above that.
- R3: In level mode (edge-select input 0), a source that is high at a clock edge while its gateway is open becomes pending at that edge. The pending bit then stays set until the source is claimed, even after the input falls.
- R4: In edge mode (edge-select input 1), only a low-to-high transition between consecutive edges sets pending. An input that stays high does not set pending again.
- R5: irq_o[k] is high exactly when some source is pending, is enabled for context k, and has a priority strictly greater than the threshold of context k. A priority of 0 never interrupts, and a threshold of 7 blocks every source (3-bit priorities).
- R6: A read of the claim register of context k returns the eligible source with the highest priority. Among equal priorities, the lowest ID wins. The read returns 0 when no source is eligible, so it returns 0 exactly when irq_o[k] is low.
- R7: A claim read clears the pending bit of the returned source at that clock edge. irq_o[k] falls in the next cycle if no other source is eligible.
- R8: A claimed source stays closed until it is completed. Neither a held level nor a new rising edge sets its pending bit again.
- R9: Writing a source ID to the claim register of a context for which that source is enabled completes the source. A level source that is still high becomes pending again at that same edge.
- R10: A complete write with an ID that is not enabled for that context is ignored, and the gateway stays closed.
- R11: A priority register keeps only its low 3 bits, and reads back those bits.
- R12: The pending array is read-only. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt inputs, bit i is source i |
| src_edge_i | input | NUM_SRC | Per-source trigger select: 1 rising edge, 0 level high |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | NUM_CTX | Interrupt request, one per context |

## Verification
The hardest state to reach is a source that is claimed but not completed while its input keeps requesting. To get there, the bench claims a source whose input is still high. It then holds the level, or drops and re-raises it in edge mode, and probes the pending word before and after complete writes aimed at the wrong context and at the right one. Priority ordering and tie-breaking are exercised by random rounds. Each round draws fresh priorities, enables, a threshold and a burst of simultaneous requests, then drains the claim register and compares every result with a model in the bench.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int PRIO_BASE   = 32'h0000_0000;
    localparam int PRIO_STRIDE = 4;
    localparam int PEND_BASE   = 32'h0000_1000;
    localparam int EN_BASE     = 32'h0000_2000;
    localparam int EN_STRIDE   = 32'h0000_0080;
    localparam int CTX_BASE    = 32'h0020_0000;
    localparam int CTX_STRIDE  = 32'h0000_1000;
    localparam int THR_OFS     = 0;
    localparam int CLAIM_OFS   = 4;

    typedef struct packed {
        logic pend;   // latched request
        logic busy;   // claimed, waiting for complete
        logic last;   // input value at the previous edge
    } gw_state_t;

endpackage

// File: rtl/pic_gateway.sv
module pic_gateway
    import pic_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic src_i,
    input  logic edge_mode_i,
    input  logic take_i,
    input  logic done_i,
    output logic pend_o,
    output logic busy_o
);

    gw_state_t s_q, s_d;
    logic      req;
    logic      open;

    always_comb begin
        s_d      = s_q;
        s_d.last = src_i;
        req      = edge_mode_i ? (src_i && !s_q.last) : src_i;
        open     = !s_q.busy || done_i;
        if (done_i) begin
            s_d.busy = 1'b0;
        end
        if (take_i) begin
            s_d.pend = 1'b0;
            s_d.busy = 1'b1;
        end else if (open && req) begin
            s_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pend_o = s_q.pend;
    assign busy_o = s_q.busy;

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    localparam int IDW    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]             pend_i,
    input  logic [NUM_SRC-1:0]             en_i,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]              thr_i,
    output logic [IDW-1:0]                 id_o,
    output logic                           ok_o
);

    logic [PRIO_W-1:0] best_pr;

    // Ascending scan with a strict compare keeps the lowest ID on ties.
    always_comb begin
        id_o    = '0;
        ok_o    = 1'b0;
        best_pr = '0;
        for (int i = 1; i < NUM_SRC; i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i] > thr_i)
                && (!ok_o || (prio_i[i] > best_pr))) begin
                ok_o    = 1'b1;
                best_pr = prio_i[i];
                id_o    = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 24
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] src_edge_i,
    input  logic               req_i,
    input  logic               we_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic [NUM_CTX-1:0] irq_o
);

    localparam int IDW       = $clog2(NUM_SRC);
    localparam int NUM_WORDS = (NUM_SRC + 31) / 32;

    typedef struct packed {
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [NUM_CTX-1:0][NUM_SRC-1:0] en;
        logic [NUM_CTX-1:0][PRIO_W-1:0]  thr;
    } regs_t;

    regs_t st_q, st_d;

    logic [NUM_SRC-1:0]          gw_pend;
    logic [NUM_SRC-1:0]          gw_busy;
    logic [NUM_SRC-1:0]          take_v;
    logic [NUM_SRC-1:0]          done_v;
    logic [NUM_CTX-1:0][IDW-1:0] arb_id;
    logic [NUM_CTX-1:0]          arb_ok;

    // Gateways: ID 0 has none.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gw
        if (g == 0) begin : g_none
            assign gw_pend[g] = 1'b0;
            assign gw_busy[g] = 1'b0;
        end else begin : g_real
            pic_gateway u_gw (
                .clk_i       (clk_i),
                .rst_ni      (rst_ni),
                .src_i       (src_i[g]),
                .edge_mode_i (src_edge_i[g]),
                .take_i      (take_v[g]),
                .done_i      (done_v[g]),
                .pend_o      (gw_pend[g]),
                .busy_o      (gw_busy[g])
            );
        end
    end

    // One arbiter per context.
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        pic_arbiter #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W)
        ) u_arb (
            .pend_i (gw_pend),
            .en_i   (st_q.en[c]),
            .prio_i (st_q.prio),
            .thr_i  (st_q.thr[c]),
            .id_o   (arb_id[c]),
            .ok_o   (arb_ok[c])
        );
        assign irq_o[c] = arb_ok[c];
    end

    // Register decode, read mux, claim and complete pulses.
    always_comb begin
        int a;
        st_d    = st_q;
        rdata_o = '0;
        take_v  = '0;
        done_v  = '0;
        a       = int'({addr_i[ADDR_W-1:2], 2'b00});
        if (req_i) begin
            for (int i = 1; i < NUM_SRC; i++) begin
                if (a == PRIO_BASE + PRIO_STRIDE * i) begin
                    rdata_o = 32'(st_q.prio[i]);
                    if (we_i) begin
                        st_d.prio[i] = wdata_i[PRIO_W-1:0];
                    end
                end
            end
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (a == PEND_BASE + 4 * w) begin
                    for (int i = 1; i < NUM_SRC; i++) begin
                        if (i / 32 == w) begin
                            rdata_o[i % 32] = gw_pend[i];
                        end
                    end
                end
            end
            for (int k = 0; k < NUM_CTX; k++) begin
                for (int w = 0; w < NUM_WORDS; w++) begin
                    if (a == EN_BASE + EN_STRIDE * k + 4 * w) begin
                        for (int i = 1; i < NUM_SRC; i++) begin
                            if (i / 32 == w) begin
                                rdata_o[i % 32] = st_q.en[k][i];
                                if (we_i) begin
                                    st_d.en[k][i] = wdata_i[i % 32];
                                end
                            end
                        end
                    end
                end
                if (a == CTX_BASE + CTX_STRIDE * k + THR_OFS) begin
                    rdata_o = 32'(st_q.thr[k]);
                    if (we_i) begin
                        st_d.thr[k] = wdata_i[PRIO_W-1:0];
                    end
                end
                if (a == CTX_BASE + CTX_STRIDE * k + CLAIM_OFS) begin
                    if (!we_i) begin
                        rdata_o = 32'(arb_id[k]);
                        for (int i = 1; i < NUM_SRC; i++) begin
                            if (arb_ok[k] && (arb_id[k] == IDW'(i))) begin
                                take_v[i] = 1'b1;
                            end
                        end
                    end else begin
                        for (int i = 1; i < NUM_SRC; i++) begin
                            if ((wdata_i == 32'(i)) && st_q.en[k][i]) begin
                                done_v[i] = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
    import pic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CTX = 2,
    parameter int ADDR_W  = 24,
    localparam int IDW    = $clog2(NUM_SRC)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               req_i,
    input logic               we_i,
    input logic [ADDR_W-1:0]  addr_i,
    input logic [31:0]        rdata_o,
    input logic [NUM_CTX-1:0] irq_o,
    input logic [NUM_SRC-1:0] pend_i,
    input logic [NUM_SRC-1:0] busy_i,
    input logic [NUM_SRC-1:0] take_i
);

    logic [ADDR_W-1:0] wa;
    assign wa = {addr_i[ADDR_W-1:2], 2'b00};

    p_id0_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && !we_i && (wa == '0)) |-> (rdata_o == '0) && !pend_i[0]);

    p_take_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(take_i));

    for (genvar k = 0; k < NUM_CTX; k++) begin : g_k
        logic          clm_rd;
        logic          clm_hit_q;
        logic [IDW-1:0] clm_id_q;
        assign clm_rd = req_i && !we_i
                        && (wa == ADDR_W'(CTX_BASE + CTX_STRIDE * k + CLAIM_OFS));

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                clm_hit_q <= 1'b0;
                clm_id_q  <= '0;
            end else begin
                clm_hit_q <= clm_rd && (rdata_o != '0);
                clm_id_q  <= rdata_o[IDW-1:0];
            end
        end

        p_claim_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clm_rd |-> ((rdata_o == '0) == !irq_o[k]));

        p_claim_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clm_hit_q |-> !pend_i[clm_id_q]);
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_s
        p_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            busy_i[i] |-> !pend_i[i]);
    end

endmodule

bind pic_core pic_core_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .ADDR_W  (ADDR_W)
) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .pend_i  (gw_pend),
    .busy_i  (gw_busy),
    .take_i  (take_v)
);

// File: tb/pic_core_tb_top.sv
module pic_core_tb_top;

    localparam logic [23:0] PEND = 24'h001000;
    localparam logic [23:0] EN0  = 24'h002000;
    localparam logic [23:0] EN1  = 24'h002080;
    localparam logic [23:0] THR0 = 24'h200000;
    localparam logic [23:0] CLM0 = 24'h200004;
    localparam logic [23:0] THR1 = 24'h201000;
    localparam logic [23:0] CLM1 = 24'h201004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic [31:0] edg = '0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int total = 0;
    int bad = 0;

    int          mprio [32];
    logic [31:0] men;
    logic [31:0] mpend;
    int          mthr;

    always #5 clk = ~clk;

    pic_core dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .src_i      (src),
        .src_edge_i (edg),
        .req_i      (req),
        .we_i       (we),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .irq_o      (irq)
    );

    function automatic logic [23:0] pa(input int id);
        return 24'(4 * id);
    endfunction

    function automatic int best();
        int b = 0;
        int bp = 0;
        for (int i = 1; i < 32; i++) begin
            if (mpend[i] && men[i] && (mprio[i] > mthr) && (mprio[i] > bp)) begin
                b = i;
                bp = mprio[i];
            end
        end
        return b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [31:0] d);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [31:0] d);
        req = 1'b1; we = 1'b0; addr = a;
        #1;
        d = rdata;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic pulse(input logic [31:0] m);
        src = m;
        @(negedge clk);
        src = '0;
    endtask

    task automatic drain();
        logic [31:0] d;
        for (int n = 0; n < 33; n++) begin
            int e;
            e = best();
            #1;
            chk("R5 irq vs model", 32'(irq[0]), 32'(e != 0));
            rd(CLM0, d);
            chk("R6 claim order", d, 32'(e));
            if (e == 0) break;
            mpend[e] = 1'b0;
            wr(CLM0, 32'(e));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R5 reset irq", 32'(irq), 32'h0);
        rd(CLM0, d); chk("R6 reset claim", d, 0);
        rd(PEND, d); chk("R3 reset pending", d, 0);

        // R1 ID 0
        wr(pa(0), 32'h5); rd(pa(0), d); chk("R1 prio id0", d, 0);
        wr(EN0, 32'h1); rd(EN0, d); chk("R1 enable id0", d, 0);

        // R11 priority width
        wr(pa(3), 32'hFF); rd(pa(3), d); chk("R11 prio mask", d, 32'h7);

        // R2 per-context placement
        wr(EN1, 32'h8);
        rd(EN0, d); chk("R2 en ctx0", d, 0);
        rd(EN1, d); chk("R2 en ctx1", d, 32'h8);
        wr(THR1, 32'h5);
        rd(THR1, d); chk("R2 thr ctx1", d, 32'h5);
        rd(THR0, d); chk("R2 thr ctx0", d, 0);
        wr(EN1, 32'h0); wr(THR1, 32'h0);

        // R12 pending read-only
        wr(PEND, 32'hFFFF_FFFF); rd(PEND, d); chk("R12 pend ro", d, 0);

        // R3/R5/R7/R8/R9/R10 level source 3
        wr(pa(3), 32'h2); wr(EN0, 32'h8);
        src[3] = 1'b1;
        @(negedge clk);
        rd(PEND, d); chk("R3 level pend", d, 32'h8);
        chk("R5 irq on", 32'(irq), 32'h1);
        wr(THR0, 32'h2); #1 chk("R5 thr equal blocks", 32'(irq[0]), 0);
        wr(THR0, 32'h7); #1 chk("R5 thr 7 blocks", 32'(irq[0]), 0);
        wr(THR0, 32'h1); #1 chk("R5 thr below", 32'(irq[0]), 1);
        rd(CLM0, d); chk("R6 claim id3", d, 3);
        #1 chk("R7 irq falls", 32'(irq[0]), 0);
        rd(PEND, d); chk("R7 pend cleared", d, 0);
        repeat (3) @(negedge clk);
        rd(PEND, d); chk("R8 level held closed", d, 0);
        wr(CLM1, 32'd3);
        rd(PEND, d); chk("R10 wrong ctx complete", d, 0);
        wr(CLM0, 32'd3);
        rd(PEND, d); chk("R9 reopen", d, 32'h8);
        src[3] = 1'b0;
        rd(CLM0, d); chk("R3 latched after drop", d, 3);
        wr(CLM0, 32'd3);
        wr(THR0, 32'h0);

        // R4 edge source 5
        edg[5] = 1'b1;
        wr(pa(5), 32'h3); wr(EN0, 32'h20);
        src[5] = 1'b1;
        repeat (3) @(negedge clk);
        rd(CLM0, d); chk("R4 edge claim", d, 5);
        wr(CLM0, 32'd5);
        repeat (2) @(negedge clk);
        rd(PEND, d); chk("R4 held high no repend", d, 0);
        src[5] = 1'b0; @(negedge clk);
        src[5] = 1'b1; @(negedge clk);
        rd(PEND, d); chk("R4 new edge pends", d, 32'h20);
        rd(CLM0, d); chk("R4 claim again", d, 5);
        src[5] = 1'b0; @(negedge clk);
        src[5] = 1'b1; @(negedge clk);
        rd(PEND, d); chk("R8 edge while closed", d, 0);
        wr(CLM0, 32'd5);
        src[5] = 1'b0;
        rd(PEND, d); chk("R4 no edge at complete", d, 0);
        edg = '0;

        // R6 priority order and tie
        wr(pa(7), 32'h4); wr(pa(8), 32'h6); wr(pa(9), 32'h4);
        wr(EN0, 32'h380);
        pulse(32'h380);
        rd(CLM0, d); chk("R6 highest prio", d, 8); wr(CLM0, 32'd8);
        rd(CLM0, d); chk("R6 tie lowest id", d, 7); wr(CLM0, 32'd7);
        rd(CLM0, d); chk("R6 last", d, 9); wr(CLM0, 32'd9);
        rd(CLM0, d); chk("R6 empty", d, 0);

        // R5 priority zero
        wr(pa(10), 32'h0); wr(EN0, 32'h400);
        pulse(32'h400);
        rd(PEND, d); chk("R3 prio0 pend", d, 32'h400);
        chk("R5 prio0 no irq", 32'(irq[0]), 0);
        rd(CLM0, d); chk("R6 prio0 claim", d, 0);
        wr(pa(10), 32'h1); #1 chk("R5 prio raised", 32'(irq[0]), 1);
        rd(CLM0, d); chk("R6 claim id10", d, 10); wr(CLM0, 32'd10);

        // random rounds
        mpend = '0;
        for (int r = 0; r < 20; r++) begin
            logic [31:0] m;
            logic [31:0] p;
            mthr = int'($urandom % 8);
            wr(THR0, 32'(mthr));
            for (int i = 1; i < 32; i++) begin
                mprio[i] = int'($urandom % 8);
                wr(pa(i), 32'(mprio[i]));
            end
            m = $urandom; m[0] = 1'b0; men = m;
            wr(EN0, m);
            p = $urandom; p[0] = 1'b0;
            pulse(p);
            mpend = p;
            rd(PEND, d); chk("R3 burst pend", d, p);
            #1 chk("R5 ctx1 idle", 32'(irq[1]), 0);
            drain();
            mthr = 0; wr(THR0, 0);
            men = 32'hFFFF_FFFE; wr(EN0, men);
            for (int i = 1; i < 32; i++) begin
                if (mpend[i]) begin
                    mprio[i] = 1;
                    wr(pa(i), 32'h1);
                end
            end
            drain();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule